// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps a running time of day as a 48-bit seconds count and a 30-bit nanoseconds count. On every reference clock cycle it advances by a programmable period. The period is an integer number of nanoseconds plus a fraction, given as a numerator over a denominator. For example, 2.5 ns is an integer part of 2 with a numerator of 1 over a denominator of 2. A remainder accumulator spreads the fraction over cycles. Each time the accumulated numerator reaches the denominator, that cycle gains one extra nanosecond.

Software works through a small word-wide register port. Period words are staged and take effect only on a commit strobe. An absolute time is staged in shadow words and copied into the counter on a load strobe. A signed nanosecond step is staged and added on an apply strobe, together with that cycle's normal increment. Reading the nanoseconds word also captures both seconds words, so a three-word read gives one consistent time.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time reads as zero seconds and zero nanoseconds, the period equals the parameter defaults (6 + 2/5 ns), `period_err` is 0, and the staging words are cleared.
- R2: Each cycle the nanoseconds grow by the integer part, plus one extra nanosecond whenever the remainder accumulator plus the numerator reaches the denominator. In that case the accumulator keeps the excess.
- R3: When the nanoseconds would reach 1,000,000,000, they wrap to the excess and the seconds grow by one. The nanoseconds never hold a value of 1,000,000,000 or more.
- R4: Writing the integer (address 0), numerator (1) or denominator (2) words does not change the running period. The staged period becomes active only when bit 0 is written as 1 at address 3, and that commit also clears the accumulator.
- R5: A commit whose staged denominator is 0, or whose numerator is not below its denominator, sets `period_err` and keeps the previous period. A later valid commit clears `period_err`.
- R6: The load words are nanoseconds (address 4), seconds high 16 bits (5) and seconds low 32 bits (6). They have no effect until bit 0 is written as 1 at address 7. On the edge of that write the time becomes exactly the loaded value.
- R7: The step word at address 8 holds a magnitude in bits [28:0] and a negative sign in bit 31; bits 30:29 are ignored. Writing bit 0 as 1 at address 9 adds the signed step and that cycle's increment to the time in one edge, carrying into the seconds when needed.
- R8: A negative step that takes the nanoseconds below zero borrows one second and leaves the nanoseconds at the sum plus 1,000,000,000.
- R9: A read returns data one cycle after `rd_en`, with `rd_valid` high. Reading address 10 returns the nanoseconds and captures the seconds. Addresses 11 (high 16 bits) and 12 (low 32 bits) return that captured value, even after the seconds have since moved on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| period_err | output | 1 | Last period commit was rejected |

## Verification
The counter is run with three periods. The default period checks the fractional carry pattern. An exact half-nanosecond period checks alternating carries. A later period with a quarter fraction checks that a commit resets the phase. Invalid commits, one with a zero denominator and one with the numerator at or above the denominator, must leave the nanosecond progression unchanged. Loads placed just below a second boundary separate a correct wrap from an off-by-one wrap, and show that the seconds captured by a nanoseconds read survive that wrap. Positive, negative and masked-bit steps separate carry, borrow and field-width handling.

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int QW      = 8,
  parameter int FW      = 24,
  parameter int SW      = 29,
  parameter int DEF_QUO = 6,
  parameter int DEF_NUM = 2,
  parameter int DEF_DEN = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        period_err
);
  localparam logic [3:0] A_QUO = 4'd0, A_NUM = 4'd1, A_DEN = 4'd2, A_PCOMMIT = 4'd3;
  localparam logic [3:0] A_LNS = 4'd4, A_LSH = 4'd5, A_LSL = 4'd6, A_LSYNC = 4'd7;
  localparam logic [3:0] A_STEP = 4'd8, A_SAPPLY = 4'd9;
  localparam logic [3:0] A_RNS = 4'd10, A_RSH = 4'd11, A_RSL = 4'd12;
  localparam logic [29:0] NS_PER_S = 30'd1_000_000_000;

  logic [QW-1:0] p_quo, a_quo;
  logic [FW-1:0] p_num, p_den, a_num, a_den, acc;
  logic [29:0]   ns_q, l_ns;
  logic [47:0]   sec_q, l_sec, snap;
  logic [SW-1:0] st_mag;
  logic          st_neg;

  wire commit    = wr_en && wr_addr == A_PCOMMIT && wr_data[0];
  wire sync_fire = wr_en && wr_addr == A_LSYNC && wr_data[0];
  wire step_fire = wr_en && wr_addr == A_SAPPLY && wr_data[0];
  wire p_ok      = (p_den != '0) && (p_num < p_den);

  wire [FW:0] acc_sum = {1'b0, acc} + {1'b0, a_num};
  wire        carry   = acc_sum >= {1'b0, a_den};
  wire [FW:0] acc_nxt = carry ? acc_sum - {1'b0, a_den} : acc_sum;
  wire [QW:0] inc     = {1'b0, a_quo} + {{QW{1'b0}}, carry};

  wire [32:0] mag_ext   = 33'(st_mag);
  wire [32:0] step_term = !step_fire ? 33'd0 : (st_neg ? 33'd0 - mag_ext : mag_ext);
  wire [32:0] tsum      = 33'(ns_q) + 33'(inc) + step_term;
  wire        under     = tsum[32];
  wire        over      = !under && (tsum >= 33'(NS_PER_S));
  wire [32:0] tfix      = under ? tsum + 33'(NS_PER_S) : (over ? tsum - 33'(NS_PER_S) : tsum);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_quo <= '0; p_num <= '0; p_den <= '0;
      a_quo <= QW'(DEF_QUO); a_num <= FW'(DEF_NUM); a_den <= FW'(DEF_DEN);
      acc <= '0; period_err <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_QUO) p_quo <= wr_data[QW-1:0];
      if (wr_en && wr_addr == A_NUM) p_num <= wr_data[FW-1:0];
      if (wr_en && wr_addr == A_DEN) p_den <= wr_data[FW-1:0];
      if (commit && p_ok) begin
        a_quo <= p_quo; a_num <= p_num; a_den <= p_den;
        acc <= '0; period_err <= 1'b0;
      end else begin
        acc <= acc_nxt[FW-1:0];
        if (commit) period_err <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q <= '0; sec_q <= '0; l_ns <= '0; l_sec <= '0;
      st_mag <= '0; st_neg <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_LNS) l_ns <= wr_data[29:0];
      if (wr_en && wr_addr == A_LSH) l_sec[47:32] <= wr_data[15:0];
      if (wr_en && wr_addr == A_LSL) l_sec[31:0] <= wr_data;
      if (wr_en && wr_addr == A_STEP) begin
        st_mag <= wr_data[SW-1:0];
        st_neg <= wr_data[31];
      end
      if (sync_fire) begin
        ns_q  <= l_ns;
        sec_q <= l_sec;
      end else begin
        ns_q  <= tfix[29:0];
        sec_q <= under ? sec_q - 48'd1 : (over ? sec_q + 48'd1 : sec_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0; rd_data <= '0; snap <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (rd_addr)
          A_RNS: begin rd_data <= {2'b0, ns_q}; snap <= sec_q; end
          A_RSH: rd_data <= {16'b0, snap[47:32]};
          A_RSL: rd_data <= snap[31:0];
          default: rd_data <= '0;
        endcase
      end
    end
  end

  assert_frac_bound_R2: assert property (@(posedge clk) disable iff (rst) acc < a_den);
  assert_ns_range_R3: assert property (@(posedge clk) disable iff (rst)
    (!sync_fire && ns_q < NS_PER_S) |=> ns_q < NS_PER_S);
  assert_sec_mono_R3: assert property (@(posedge clk) disable iff (rst)
    (!sync_fire && !step_fire) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 48'd1));
  assert_period_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(a_quo) && $stable(a_num) && $stable(a_den)));
  assert_bad_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && !p_ok) |=> (period_err && $stable(a_den) && $stable(a_num)));
  assert_rd_lat_R9: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid);
endmodule

// File: tb/tb_ptp_time_counter.sv
module tb_ptp_time_counter;
  localparam longint NS = 1_000_000_000;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic rd_valid, period_err;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  ptp_time_counter dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .period_err(period_err));

  always #5 clk = ~clk;

  longint m_tot, m_quo, m_num, m_den, m_acc, p_quo, p_num, p_den, l_ns, l_sec, s_mag, m_inc, m_a;
  bit s_neg, m_err, m_c;
  longint snap_sec;

  always @(posedge clk) begin
    if (rst) begin
      m_tot = 0; m_quo = 6; m_num = 2; m_den = 5; m_acc = 0; m_err = 0;
      p_quo = 0; p_num = 0; p_den = 0; l_ns = 0; l_sec = 0; s_mag = 0; s_neg = 0;
    end else begin
      m_a = m_acc + m_num; m_c = (m_a >= m_den); if (m_c) m_a = m_a - m_den;
      m_inc = m_quo + longint'(m_c);
      if (wr_en && wr_addr == 7 && wr_data[0]) m_tot = l_sec * NS + l_ns;
      else if (wr_en && wr_addr == 9 && wr_data[0]) m_tot = m_tot + m_inc + (s_neg ? -s_mag : s_mag);
      else m_tot = m_tot + m_inc;
      m_acc = m_a;
      if (wr_en && wr_addr == 3 && wr_data[0]) begin
        if (p_den != 0 && p_num < p_den) begin
          m_quo = p_quo; m_num = p_num; m_den = p_den; m_acc = 0; m_err = 0;
        end else m_err = 1;
      end
      if (wr_en) case (wr_addr)
        0: p_quo = wr_data[7:0];
        1: p_num = wr_data[23:0];
        2: p_den = wr_data[23:0];
        4: l_ns = wr_data[29:0];
        5: l_sec = {wr_data[15:0], l_sec[31:0]};
        6: l_sec = {l_sec[47:32], wr_data};
        8: begin s_mag = wr_data[28:0]; s_neg = wr_data[31]; end
        default: ;
      endcase
    end
  end

  longint exp_q[$];
  string tag_q[$];

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input longint d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk); rd_en = 1'b1; rd_addr = 4'(a);
    if (a == 10) begin exp_q.push_back(m_tot % NS); snap_sec = m_tot / NS; end
    else if (a == 11) exp_q.push_back(snap_sec >> 32);
    else exp_q.push_back(snap_sec & 64'hFFFF_FFFF);
    tag_q.push_back(req);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R9 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), longint'(rd_data), exp_q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 period_err after reset", longint'(period_err), 0);
    check("R9 rd_valid after reset", longint'(rd_valid), 0);
    rd(10, "R1 ns after reset");
    rd(11, "R1 sec_hi after reset");
    rd(12, "R1 sec_lo after reset");
    idle(7); rd(10, "R2 default fraction"); idle(3); rd(10, "R2 default fraction later");
    wr(0, 2); wr(1, 1); wr(2, 2);
    rd(10, "R4 staged period not active"); idle(5); rd(10, "R4 staged period not active later");
    wr(3, 1); idle(4); rd(10, "R2 half-ns period"); idle(3); rd(10, "R2 half-ns period later");
    wr(2, 0); wr(3, 1);
    check("R5 zero denominator flagged", longint'(period_err), 1);
    idle(3); rd(10, "R5 period kept after zero den");
    wr(2, 2); wr(1, 3); wr(3, 1);
    check("R5 numerator >= denominator flagged", longint'(period_err), 1);
    rd(10, "R5 period kept after big num");
    wr(0, 3); wr(1, 1); wr(2, 4); wr(3, 1);
    check("R5 valid commit clears flag", longint'(period_err), 0);
    idle(2); rd(10, "R2 quarter period");
    wr(4, 999_999_900); wr(5, 1); wr(6, 7);
    rd(10, "R6 shadow not applied"); rd(12, "R6 shadow not applied sec");
    wr(7, 1);
    rd(10, "R6 loaded ns"); rd(11, "R6 loaded sec_hi"); rd(12, "R6 loaded sec_lo");
    idle(40); rd(10, "R3 ns after wrap"); rd(12, "R3 sec after wrap"); rd(11, "R3 sec_hi after wrap");
    wr(4, 999_999_985); wr(5, 0); wr(6, 20); wr(7, 1);
    rd(10, "R9 snapshot ns"); idle(12); rd(12, "R9 snapshot sec held");
    rd(10, "R9 fresh ns"); rd(12, "R9 fresh sec");
    wr(4, 600_000_000); wr(6, 10); wr(7, 1);
    wr(8, 500_000_000); wr(9, 1);
    rd(10, "R7 positive step ns"); rd(12, "R7 positive step carry sec");
    wr(8, 64'h8000_0000 | 700_000_000); wr(9, 1);
    rd(10, "R8 negative step ns"); rd(12, "R8 negative step borrow sec");
    wr(8, 64'h6000_0000 | 100); wr(9, 1);
    rd(10, "R7 masked step bits"); rd(12, "R7 masked step sec");
    idle(3);
    check("R9 all reads answered", longint'(exp_q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule